// File: doc/BRIEF.md
# Directory LL/SC Reservation Table

This block tracks load-linked / store-conditional reservations inside a shared memory-cache directory. For every cache line it keeps a chain of copy entries, one per L1 cache (source) holding that line. Each entry stores the source identifier and one reservation flag. The entries come from a fixed pool, and a free map hands them out. There is no separate reservation store: the flag on the copy entry is the reservation.

Requests arrive one at a time with an opcode, a source identifier and an address. Address bits below `OFFSET_W` select a word inside the line and are not used. The next `LINE_W` bits select the directory line, and any bits above those are not compared, because tag matching is outside this block. Each accepted request walks the line's chain one entry per clock and ends with a one-cycle response carrying a pass/fail flag.

Reservations are held per line, not per word. A write to any word of a line therefore breaks reservations on the other words of that line, which is a false conflict.

Top module: `rsv_table`

## Requirements
- R1: After reset, `busy` and `resp_valid` are low and every line has an empty chain, so an SC to any line fails with a response 1 cycle after acceptance.
- R2: An LL (`req_op`=2'b01) from a source with no copy on the line allocates a new entry with its reservation set and responds `resp_ok`=1. A later SC (`req_op`=2'b10) from that source on that line succeeds.
- R3: An LL from a source that already has an entry on the line sets that entry's reservation and allocates no second entry. The chain length, and so the SC latency, does not change.
- R4: An SC passes (`resp_ok`=1) only when the requester's entry on the line is found with its reservation set. An SC from a source with no entry, or with no reservation, fails.
- R5: A successful SC clears every reservation on that line, including the requester's. After it, any SC on that line fails until a new LL.
- R6: A failed SC leaves all reservation flags unchanged.
- R7: A write (`req_op`=2'b11) clears every reservation on its line and responds `resp_ok`=1. Reservations on other lines are untouched.
- R8: Address bits [OFFSET_W-1:0] are ignored. A write to one word of a line breaks an LL made on a different word of the same line.
- R9: An LL that needs a new entry when the pool is full responds `resp_ok`=0 and changes no state.
- R10: `busy` is high from the cycle after acceptance until the response cycle. Requests presented while `busy` is high are ignored. `resp_valid` is a single-cycle pulse, one per accepted request, and never coincides with `busy`. Opcode 2'b00 is never accepted.
- R11: The chain walk visits one entry per cycle. Counting clock edges from the accepting edge to the edge after which `resp_valid` is high, on a line holding n ≥ 1 entries:
  - a failed SC takes n;
  - a successful SC takes 2n (a scan pass followed by a clear pass);
  - a write takes n;
  - on an empty line, any of these takes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 2 | 00 none, 01 LL, 10 SC, 11 write |
| req_src | input | SRC_W | Requesting L1 cache identifier |
| req_addr | input | ADDR_W | Byte/word address of the access |
| busy | output | 1 | Walk in progress; new requests ignored |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | Pass flag, meaningful with `resp_valid` |

## Verification
SCs are tried against four kinds of line:
- an empty line;
- a line with one reserving copy;
- a three-copy chain, probed by a source holding no copy, by the reserving source, and by sources whose reservations were just consumed;
- a chain whose reservation was broken by a write to another word of the same line.

The response latency tells a scan-only failure (n cycles) apart from a scan-then-clear success (2n). The same latency shows whether a repeated LL grew the chain.

Filling the pool separates a refused allocation from an LL that reuses an existing entry. A request issued mid-walk shows whether the busy interlock drops it.

// File: rtl/rsv_pkg.sv
// Shared types for the directory reservation table.
// Assumes a two-bit opcode field on the request port.
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_LL   = 2'b01,
        OP_SC   = 2'b10,
        OP_WR   = 2'b11
    } rsv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SCAN  = 2'b01,
        ST_CLEAR = 2'b10,
        ST_DONE  = 2'b11
    } rsv_state_e;

endpackage

// File: rtl/rsv_entry_pool.sv
// Copy-entry pool: DEPTH entries, each with source id, reservation flag,
// link to the next entry and link-valid bit. One read port addressed by
// rd_idx; set/clear of the reservation act on rd_idx; allocation writes the
// lowest free entry. Entries are never released here (eviction lives elsewhere).
module rsv_entry_pool #(
    parameter int DEPTH = 8,
    parameter int SRC_W = 3,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SRC_W-1:0] rd_src,
    output logic             rd_rsv,
    output logic [IDX_W-1:0] rd_next,
    output logic             rd_next_vld,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic             alloc_en,
    input  logic [SRC_W-1:0] alloc_src,
    input  logic [IDX_W-1:0] alloc_next,
    input  logic             alloc_next_vld,
    output logic [IDX_W-1:0] free_idx,
    output logic             free_any
);

    logic [SRC_W-1:0] src_a  [DEPTH];
    logic [IDX_W-1:0] next_a [DEPTH];
    logic [DEPTH-1:0] rsv_a;
    logic [DEPTH-1:0] nvld_a;
    logic [DEPTH-1:0] used_a;

    // Entry storage update: allocation, reservation set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                src_a[i]  <= '0;
                next_a[i] <= '0;
            end
            rsv_a  <= '0;
            nvld_a <= '0;
            used_a <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_en && free_any && (free_idx == IDX_W'(i))) begin
                    src_a[i]  <= alloc_src;
                    next_a[i] <= alloc_next;
                    nvld_a[i] <= alloc_next_vld;
                    rsv_a[i]  <= 1'b1;
                    used_a[i] <= 1'b1;
                end else if (set_en && (rd_idx == IDX_W'(i))) begin
                    rsv_a[i] <= 1'b1;
                end else if (clr_en && (rd_idx == IDX_W'(i))) begin
                    rsv_a[i] <= 1'b0;
                end
            end
        end
    end

    // Read port for the chain walker.
    always_comb begin
        rd_src      = src_a[rd_idx];
        rd_rsv      = rsv_a[rd_idx];
        rd_next     = next_a[rd_idx];
        rd_next_vld = nvld_a[rd_idx];
    end

    // Free map: pick the lowest unused entry.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used_a[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rsv_line_heads.sv
// Per-line chain head registers: one head index and valid bit per directory
// line. A new entry is always pushed at the head of its line's chain.
module rsv_line_heads #(
    parameter int LINES  = 4,
    parameter int IDX_W  = 3,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic [IDX_W-1:0]  rd_head,
    output logic              rd_head_vld,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [IDX_W-1:0]  upd_idx
);

    logic [IDX_W-1:0] head_a [LINES];
    logic [LINES-1:0] hvld_a;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [IDX_W-1:0] head_q;
        logic             vld_q;

        // Head register of one line, loaded on a push to that line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head_q <= '0;
                vld_q  <= 1'b0;
            end else if (upd_en && (upd_line == LINE_W'(g))) begin
                head_q <= upd_idx;
                vld_q  <= 1'b1;
            end
        end

        assign head_a[g] = head_q;
        assign hvld_a[g] = vld_q;
    end

    assign rd_head     = head_a[rd_line];
    assign rd_head_vld = hvld_a[rd_line];

endmodule

// File: rtl/rsv_table.sv
// Directory reservation table top. Accepts one LL / SC / write at a time,
// walks the addressed line's copy chain one entry per cycle and returns a
// one-cycle pass/fail response. SC uses a scan pass then, on success, a clear
// pass. Assumes the line index is taken directly from the address; tag
// comparison is done outside.
module rsv_table #(
    parameter int NUM_LINES  = 4,
    parameter int POOL_DEPTH = 8,
    parameter int SRC_W      = 3,
    parameter int OFFSET_W   = 2,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_ok
);
    import rsv_pkg::*;

    localparam int LINE_W = $clog2(NUM_LINES);
    localparam int IDX_W  = $clog2(POOL_DEPTH);

    rsv_state_e        state, st_n;
    rsv_op_e           op_q, op_n;
    logic [SRC_W-1:0]  src_q, src_n;
    logic [LINE_W-1:0] line_q, line_n;
    logic [IDX_W-1:0]  ptr, ptr_n;
    logic              ptr_vld, pvld_n;
    logic              hit_q, hit_n;
    logic              ok_q, ok_n;

    logic [LINE_W-1:0] req_line, hd_line;
    logic [IDX_W-1:0]  hd_idx, rd_next, free_idx;
    logic              hd_vld, rd_next_vld, rd_rsv, free_any;
    logic [SRC_W-1:0]  rd_src;
    logic              set_en, clr_en, alloc_en, upd_en;
    logic              idle, match, last;

    assign req_line = req_addr[OFFSET_W +: LINE_W];
    assign idle     = (state == ST_IDLE) || (state == ST_DONE);
    assign hd_line  = idle ? req_line : line_q;
    assign match    = ptr_vld && (rd_src == src_q);
    assign last     = !ptr_vld || !rd_next_vld;

    rsv_entry_pool #(.DEPTH(POOL_DEPTH), .SRC_W(SRC_W), .IDX_W(IDX_W)) u_pool (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_idx         (ptr),
        .rd_src         (rd_src),
        .rd_rsv         (rd_rsv),
        .rd_next        (rd_next),
        .rd_next_vld    (rd_next_vld),
        .set_en         (set_en),
        .clr_en         (clr_en),
        .alloc_en       (alloc_en),
        .alloc_src      (src_q),
        .alloc_next     (hd_idx),
        .alloc_next_vld (hd_vld),
        .free_idx       (free_idx),
        .free_any       (free_any)
    );

    rsv_line_heads #(.LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_heads (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_line     (hd_line),
        .rd_head     (hd_idx),
        .rd_head_vld (hd_vld),
        .upd_en      (upd_en),
        .upd_line    (line_q),
        .upd_idx     (free_idx)
    );

    // Next-state and entry-control decode for the chain walker.
    always_comb begin
        st_n     = state;
        op_n     = op_q;
        src_n    = src_q;
        line_n   = line_q;
        ptr_n    = ptr;
        pvld_n   = ptr_vld;
        hit_n    = hit_q;
        ok_n     = ok_q;
        set_en   = 1'b0;
        clr_en   = 1'b0;
        alloc_en = 1'b0;
        upd_en   = 1'b0;
        case (state)
            ST_IDLE, ST_DONE: begin
                if (req_valid && (rsv_op_e'(req_op) != OP_NONE)) begin
                    op_n   = rsv_op_e'(req_op);
                    src_n  = req_src;
                    line_n = req_line;
                    ptr_n  = hd_idx;
                    pvld_n = hd_vld;
                    hit_n  = 1'b0;
                    ok_n   = 1'b0;
                    st_n   = (rsv_op_e'(req_op) == OP_WR) ? ST_CLEAR : ST_SCAN;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (op_q == OP_LL) begin
                    if (match) begin
                        set_en = 1'b1;
                        ok_n   = 1'b1;
                        st_n   = ST_DONE;
                    end else if (last) begin
                        alloc_en = free_any;
                        upd_en   = free_any;
                        ok_n     = free_any;
                        st_n     = ST_DONE;
                    end else begin
                        ptr_n  = rd_next;
                        pvld_n = 1'b1;
                    end
                end else begin
                    hit_n = hit_q || (match && rd_rsv);
                    if (last) begin
                        if (hit_n) begin
                            ptr_n  = hd_idx;
                            pvld_n = hd_vld;
                            st_n   = ST_CLEAR;
                        end else begin
                            ok_n = 1'b0;
                            st_n = ST_DONE;
                        end
                    end else begin
                        ptr_n  = rd_next;
                        pvld_n = 1'b1;
                    end
                end
            end
            ST_CLEAR: begin
                clr_en = ptr_vld;
                if (last) begin
                    ok_n = 1'b1;
                    st_n = ST_DONE;
                end else begin
                    ptr_n  = rd_next;
                    pvld_n = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Walker state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_NONE;
            src_q   <= '0;
            line_q  <= '0;
            ptr     <= '0;
            ptr_vld <= 1'b0;
            hit_q   <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            state   <= st_n;
            op_q    <= op_n;
            src_q   <= src_n;
            line_q  <= line_n;
            ptr     <= ptr_n;
            ptr_vld <= pvld_n;
            hit_q   <= hit_n;
            ok_q    <= ok_n;
        end
    end

    assign busy       = (state == ST_SCAN) || (state == ST_CLEAR);
    assign resp_valid = (state == ST_DONE);
    assign resp_ok    = resp_valid && ok_q;

endmodule

// File: rtl/rsv_table_chk.sv
// Protocol checker for rsv_table, bound to every instance.
module rsv_table_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       busy,
    input logic       resp_valid,
    input logic       resp_ok
);
    logic [1:0] last_op;

    // Remember the opcode of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_op <= 2'b00;
        else if (req_valid && (req_op != 2'b00) && !busy)
            last_op <= req_op;
    end

    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && resp_valid));

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op != 2'b00) && !busy) |=> busy);

    assert_busy_ends_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || resp_valid));

    assert_write_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (last_op == 2'b11)) |-> resp_ok);

    assert_idle_no_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_valid && (req_op != 2'b00))) |=> !resp_valid);

endmodule

bind rsv_table rsv_table_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_ok    (resp_ok)
);

// File: tb/tb_rsv_table.sv
`timescale 1ns/1ps
// Directed bench for rsv_table: one task per scenario.
module tb_rsv_table;
    localparam int SRC_W  = 3;
    localparam int ADDR_W = 8;
    localparam logic [1:0] LL = 2'b01, SC = 2'b10, WR = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [SRC_W-1:0]  req_src = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              busy, resp_valid, resp_ok;

    int checks = 0;
    int errors = 0;

    rsv_table dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_src(req_src), .req_addr(req_addr), .busy(busy),
        .resp_valid(resp_valid), .resp_ok(resp_ok)
    );

    always #4 clk = ~clk;

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] addr(input int line, input int word);
        return ADDR_W'(line * 4 + word);
    endfunction

    // Issue one request, wait for its response, return pass flag and latency.
    task automatic issue(input logic [1:0] op, input int src, input int line, input int word,
                         output bit ok, output int lat);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_src = SRC_W'(src); req_addr = addr(line, word);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
        lat = 0;
        while (!resp_valid && lat < 100) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        ok = resp_ok;
    endtask

    task automatic expect_req(input logic [1:0] op, input int src, input int line, input int word,
                              input bit exp_ok, input int exp_lat, input string tag);
        bit ok; int lat;
        issue(op, src, line, word, ok, lat);
        check(ok == exp_ok, {tag, " ok"}, ok, exp_ok);
        if (exp_lat > 0) check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    endtask

    task automatic t_reset();
        check(!busy, "R1 busy after reset", busy, 0);
        check(!resp_valid, "R1 resp_valid after reset", resp_valid, 0);
        expect_req(SC, 1, 0, 0, 0, 1, "R1 SC on empty line");
    endtask

    task automatic t_ll_sc();
        expect_req(LL, 1, 1, 0, 1, 1, "R2 LL new source");
        expect_req(SC, 1, 1, 0, 1, 2, "R2 R11 SC after LL");
        expect_req(SC, 1, 1, 0, 0, 1, "R5 repeat SC");
    endtask

    task automatic t_conflict();
        expect_req(LL, 1, 2, 0, 1, 0, "R2 LL src1 line2");
        expect_req(LL, 2, 2, 1, 1, 0, "R2 LL src2 line2");
        expect_req(LL, 3, 2, 2, 1, 0, "R2 LL src3 line2");
        expect_req(SC, 4, 2, 0, 0, 3, "R4 R11 SC no copy");
        expect_req(SC, 2, 2, 1, 1, 6, "R6 R11 SC after failed SC");
        expect_req(SC, 1, 2, 0, 0, 3, "R5 src1 after clear");
        expect_req(SC, 3, 2, 2, 0, 3, "R5 src3 after clear");
    endtask

    task automatic t_reuse();
        expect_req(LL, 1, 2, 3, 1, 0, "R3 LL existing source");
        expect_req(SC, 1, 2, 3, 1, 6, "R3 chain length unchanged");
    endtask

    task automatic t_write();
        expect_req(LL, 5, 3, 1, 1, 0, "R7 LL line3");
        expect_req(LL, 1, 1, 0, 1, 0, "R7 LL line1");
        expect_req(WR, 6, 3, 3, 1, 1, "R7 R11 write line3");
        expect_req(SC, 5, 3, 1, 0, 1, "R8 false conflict SC");
        expect_req(SC, 1, 1, 0, 1, 2, "R7 other line kept");
    endtask

    task automatic t_pool_full();
        expect_req(LL, 1, 0, 0, 1, 1, "R9 fill 6");
        expect_req(LL, 2, 0, 0, 1, 1, "R9 fill 7");
        expect_req(LL, 3, 0, 0, 1, 2, "R9 fill 8");
        expect_req(LL, 4, 0, 0, 0, 3, "R9 LL pool full");
        expect_req(LL, 2, 0, 0, 1, 0, "R3 LL existing when full");
        expect_req(SC, 2, 0, 0, 1, 6, "R9 no state change");
    endtask

    task automatic t_busy();
        bit ok; int lat;
        expect_req(LL, 1, 1, 0, 1, 0, "R10 setup LL");
        @(negedge clk);
        req_valid = 1'b1; req_op = SC; req_src = 3'd1; req_addr = addr(2, 0);
        @(posedge clk);
        @(negedge clk);
        check(busy, "R10 busy after accept", busy, 1);
        req_op = WR; req_addr = addr(1, 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
        lat = 1;
        while (!resp_valid && lat < 100) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check(lat == 3, "R10 R11 SC latency while held", lat, 3);
        check(!resp_ok, "R10 SC result", resp_ok, 0);
        @(negedge clk);
        check(!resp_valid && !busy, "R10 single response", resp_valid, 0);
        req_valid = 1'b1; req_op = 2'b00;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!busy && !resp_valid, "R10 no-op not accepted", busy, 0);
        issue(SC, 1, 1, 0, ok, lat);
        check(ok, "R10 write during busy ignored", ok, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ll_sc();
        t_conflict();
        t_reuse();
        t_write();
        t_pool_full();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule